// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block chooses which interrupt a small 8-bit processor core takes next. Its inputs are a system reset request, a software-interrupt request from the instruction decoder, and six peripheral request flags. Each peripheral flag comes with its own control bit. The block applies the core's global interrupt mask and picks the most urgent source. It then presents a take request together with the 16-bit address of the vector's high byte. The low byte sits at that address plus one.

Selection happens only when the core pulses an instruction-boundary strobe. The chosen vector and its type are then held until the core acknowledges them. On acknowledge, the block asks the core to set its global mask. The type output tells the stacking logic which return address to push. A software interrupt pushes the current PC. A hardware interrupt pushes PC minus one.

The block also drives three read-only status bytes. In these bytes every locally enabled pending peripheral shows up at a fixed, sparse bit position, whatever the state of the global mask. A debugger can therefore see requests that the global mask is holding back.

Top module: `prio_vec_ctrl`

## Requirements
- R1: Among eligible requests, the winner follows this order, most urgent first: reset request, software interrupt, IRQ (src index 0), timer channel 0 (1), timer channel 1 (2), timer overflow (3), keyboard (4), ADC complete (5).
- R2: `vec_addr` holds the high-byte vector address, as follows.
  - reset FFFE
  - software FFFC
  - IRQ FFFA
  - timer channel 0 FFF6
  - timer channel 1 FFF4
  - timer overflow FFF2
  - keyboard FFE0
  - ADC FFDF-1 = FFDE
- R3: When `i_mask`=1, no peripheral source can be selected. A software interrupt and a reset request are still accepted.
- R4: A peripheral is qualified when its `src_flag` bit is 1 and its `src_ctl` bit enables it. For indices 0 (IRQ) and 4 (keyboard), a control bit of 1 masks the source. For indices 1, 2, 3 and 5, a control bit of 1 enables it.
- R5: The qualified flags are mirrored into a 24-bit status space, where flat bit n lies in `stat1` for n=0..7, `stat2` for n=8..15 and `stat3` for n=16..23. The bit positions are IRQ→1, ch0→3, ch1→4, overflow→5, keyboard→14, ADC→15. Every other bit reads 0.
- R6: The status bits do not depend on `i_mask` or on any take or acknowledge activity.
- R7: `take_kind` encodes the held selection: 0 none, 1 reset, 2 software, 3 hardware. `stack_pc_minus1` is 1 exactly when a hardware vector is held.
- R8: A new selection is loaded only on a clock edge where `boundary`=1 and nothing is held. The first edge after that shows `take_req`=1. A held selection keeps the same vector and type until it is acknowledged, whatever the inputs do.
- R9: A `rst_req` on a clock edge replaces any held selection with the reset vector, whatever the masks, the boundary strobe or `ack`. The reset vector appears on the next cycle.
- R10: `set_imask` is 1 in exactly the cycles where a held selection is acknowledged (`take_req`=1, `ack`=1, `rst_req`=0).
- R11: An acknowledge clears the held selection on that edge. No new selection is loaded on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | System reset request, highest priority |
| swi_req | input | 1 | Software interrupt request from the decoder |
| boundary | input | 1 | Instruction-boundary strobe, arbitration sample point |
| ack | input | 1 | Core accepts the held vector |
| i_mask | input | 1 | Global interrupt mask from the core |
| src_flag | input | 6 | Raw peripheral request flags |
| src_ctl | input | 6 | Per-source mask/enable bits |
| take_req | output | 1 | A vector is held for the core |
| take_kind | output | 2 | Type of held vector |
| vec_addr | output | 16 | Vector high-byte fetch address |
| stack_pc_minus1 | output | 1 | Stack PC-1 (hardware) instead of PC |
| set_imask | output | 1 | Request the core to set its global mask |
| stat1 | output | 8 | Status byte, flat bits 7..0 |
| stat2 | output | 8 | Status byte, flat bits 15..8 |
| stat3 | output | 8 | Status byte, flat bits 23..16 (reserved, zero) |

## Verification
The bench sweeps every combination of the six flags, the six control bits, the global mask and the software request. In each case it checks both the winner and the status bytes. This exposes a wrong priority, a swapped vector, an inverted control polarity on IRQ or keyboard, and a global mask that wrongly blocks the software interrupt or leaks into the status bytes. Directed sequences check three things that a careless holding register would get wrong. A held vector must not change when the inputs change without an acknowledge. No selection may happen without the boundary strobe. A reset request must override a held hardware vector even when the mask is set, the strobe is low and `ack` is high.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  localparam int NHW    = 6;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_RST  = 2'd1,
    K_SWI  = 2'd2,
    K_HW   = 2'd3
  } kind_t;

  // Control bits that mask when set (IRQ and keyboard); the others enable.
  localparam logic [NHW-1:0] SET_MASKS = 6'b010001;

  localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFE;
  localparam logic [ADDR_W-1:0] VEC_SWI = 16'hFFFC;

  function automatic logic [ADDR_W-1:0] hw_vector(input int idx);
    logic [ADDR_W-1:0] v;
    case (idx)
      0:       v = 16'hFFFA;
      1:       v = 16'hFFF6;
      2:       v = 16'hFFF4;
      3:       v = 16'hFFF2;
      4:       v = 16'hFFE0;
      default: v = 16'hFFDE;
    endcase
    return v;
  endfunction

  function automatic int status_bit(input int idx);
    int b;
    case (idx)
      0:       b = 1;
      1:       b = 3;
      2:       b = 4;
      3:       b = 5;
      4:       b = 14;
      default: b = 15;
    endcase
    return b;
  endfunction

  function automatic logic [NHW-1:0] qualify(input logic [NHW-1:0] flag,
                                             input logic [NHW-1:0] ctl);
    return flag & (ctl ^ SET_MASKS);
  endfunction
endpackage

// File: rtl/pvc_qualify.sv
module pvc_qualify
  import pvc_pkg::*;
(
  input  logic [NHW-1:0] src_flag,
  input  logic [NHW-1:0] src_ctl,
  input  logic           i_mask,
  output logic [NHW-1:0] qual,
  output logic [NHW-1:0] elig
);
  assign qual = qualify(src_flag, src_ctl);
  assign elig = qual & {NHW{~i_mask}};
endmodule

// File: rtl/pvc_arbiter.sv
module pvc_arbiter
  import pvc_pkg::*;
(
  input  logic              swi_req,
  input  logic [NHW-1:0]    elig,
  output logic              cand_valid,
  output kind_t             cand_kind,
  output logic [ADDR_W-1:0] cand_vec
);
  localparam int IDX_W = $clog2(NHW);

  logic             hw_any;
  logic [IDX_W-1:0] hw_idx;

  always_comb begin
    hw_idx = '0;
    for (int i = NHW - 1; i >= 0; i--) begin
      if (elig[i]) hw_idx = IDX_W'(i);
    end
  end

  assign hw_any     = |elig;
  assign cand_valid = swi_req | hw_any;
  assign cand_kind  = swi_req ? K_SWI : K_HW;
  assign cand_vec   = swi_req ? VEC_SWI : hw_vector(int'(hw_idx));
endmodule

// File: rtl/pvc_hold.sv
module pvc_hold
  import pvc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              boundary,
  input  logic              ack,
  input  logic              cand_valid,
  input  kind_t             cand_kind,
  input  logic [ADDR_W-1:0] cand_vec,
  output logic              held,
  output kind_t             held_kind,
  output logic [ADDR_W-1:0] held_vec,
  output logic              take_evt,
  output logic              load_evt
);
  assign take_evt = held & ack & ~rst_req;
  assign load_evt = ~held & boundary & cand_valid & ~rst_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_kind <= K_NONE;
      held_vec  <= '0;
    end else if (rst_req) begin
      held      <= 1'b1;
      held_kind <= K_RST;
      held_vec  <= VEC_RST;
    end else if (take_evt) begin
      held      <= 1'b0;
      held_kind <= K_NONE;
    end else if (load_evt) begin
      held      <= 1'b1;
      held_kind <= cand_kind;
      held_vec  <= cand_vec;
    end
  end
endmodule

// File: rtl/pvc_status.sv
module pvc_status
  import pvc_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int NREG  = 3
) (
  input  logic [NHW-1:0]        qual,
  output logic [NREG*REG_W-1:0] flat
);
  always_comb begin
    flat = '0;
    for (int g = 0; g < NHW; g++) begin
      flat[status_bit(g)] = qual[g];
    end
  end
endmodule

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl
  import pvc_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req,
  input  logic              swi_req,
  input  logic              boundary,
  input  logic              ack,
  input  logic              i_mask,
  input  logic [NHW-1:0]    src_flag,
  input  logic [NHW-1:0]    src_ctl,
  output logic              take_req,
  output logic [1:0]        take_kind,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              stack_pc_minus1,
  output logic              set_imask,
  output logic [REG_W-1:0]  stat1,
  output logic [REG_W-1:0]  stat2,
  output logic [REG_W-1:0]  stat3
);
  localparam int NREG = 3;

  logic [NHW-1:0]         qual, elig;
  logic                   cand_valid;
  kind_t                  cand_kind, held_kind;
  logic [ADDR_W-1:0]      cand_vec, held_vec;
  logic                   held, take_evt, load_evt;
  logic [NREG*REG_W-1:0]  flat;

  pvc_qualify u_qual (
    .src_flag(src_flag), .src_ctl(src_ctl), .i_mask(i_mask),
    .qual(qual), .elig(elig)
  );

  pvc_arbiter u_arb (
    .swi_req(swi_req), .elig(elig),
    .cand_valid(cand_valid), .cand_kind(cand_kind), .cand_vec(cand_vec)
  );

  pvc_hold u_hold (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .boundary(boundary),
    .ack(ack), .cand_valid(cand_valid), .cand_kind(cand_kind),
    .cand_vec(cand_vec), .held(held), .held_kind(held_kind),
    .held_vec(held_vec), .take_evt(take_evt), .load_evt(load_evt)
  );

  pvc_status #(.REG_W(REG_W), .NREG(NREG)) u_stat (
    .qual(qual), .flat(flat)
  );

  assign take_req        = held;
  assign take_kind       = held_kind;
  assign vec_addr        = held_vec;
  assign stack_pc_minus1 = held & (held_kind == K_HW);
  assign set_imask       = take_evt;
  assign stat1           = flat[REG_W-1:0];
  assign stat2           = flat[2*REG_W-1:REG_W];
  assign stat3           = flat[3*REG_W-1:2*REG_W];
endmodule

// File: rtl/prio_vec_ctrl_chk.sv
module prio_vec_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rst_req,
  input logic        swi_req,
  input logic        boundary,
  input logic        ack,
  input logic        i_mask,
  input logic        take_req,
  input logic [1:0]  take_kind,
  input logic [15:0] vec_addr,
  input logic        stack_pc_minus1,
  input logic        set_imask
);
  // R9
  rst_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> take_req && take_kind == 2'd1 && vec_addr == 16'hFFFE);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && !ack && !rst_req |=> take_req && $stable(vec_addr) && $stable(take_kind));

  // R8
  no_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_req && !rst_req && !boundary |=> !take_req);

  // R3
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_req && !rst_req && i_mask && !swi_req |=> !take_req);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && ack && !rst_req |=> !take_req);

  // R10
  set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_imask |-> take_req && ack);

  // R7
  pc_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_pc_minus1 |-> vec_addr < 16'hFFFC && vec_addr[15:8] == 8'hFF);
endmodule

bind prio_vec_ctrl prio_vec_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .swi_req(swi_req),
  .boundary(boundary), .ack(ack), .i_mask(i_mask), .take_req(take_req),
  .take_kind(take_kind), .vec_addr(vec_addr),
  .stack_pc_minus1(stack_pc_minus1), .set_imask(set_imask)
);

// File: tb/prio_vec_ctrl_test.sv
`timescale 1ns/1ps
module prio_vec_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_req = 0, swi_req = 0, boundary = 0, ack = 0, i_mask = 0;
  logic [5:0] src_flag = '0, src_ctl = '0;
  logic take_req, stack_pc_minus1, set_imask;
  logic [1:0] take_kind;
  logic [15:0] vec_addr;
  logic [7:0] stat1, stat2, stat3;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_vec_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .swi_req(swi_req),
    .boundary(boundary), .ack(ack), .i_mask(i_mask), .src_flag(src_flag),
    .src_ctl(src_ctl), .take_req(take_req), .take_kind(take_kind),
    .vec_addr(vec_addr), .stack_pc_minus1(stack_pc_minus1),
    .set_imask(set_imask), .stat1(stat1), .stat2(stat2), .stat3(stat3)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] exp_vec(input int idx);
    logic [15:0] t [6] = '{16'hFFFA, 16'hFFF6, 16'hFFF4, 16'hFFF2, 16'hFFE0, 16'hFFDE};
    return t[idx];
  endfunction

  task automatic expect_held(input string req, input logic [1:0] k,
                             input logic [15:0] v);
    check(take_req === 1'b1, req, {31'b0, take_req}, 32'd1);
    check(take_kind === k, req, {30'b0, take_kind}, {30'b0, k});
    check(vec_addr === v, req, {16'b0, vec_addr}, {16'b0, v});
    check(stack_pc_minus1 === (k == 2'd3), req, {31'b0, stack_pc_minus1},
          {31'b0, (k == 2'd3)});
  endtask

  initial begin : watchdog
    #(CLK_P * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    #1;
    // reset state
    check(take_req === 1'b0, "R7 reset take", {31'b0, take_req}, 0);
    check(take_kind === 2'd0, "R7 reset kind", {30'b0, take_kind}, 0);
    check({stat3, stat2, stat1} === 24'd0, "R5 reset status",
          {8'b0, stat3, stat2, stat1}, 0);
    rst_n = 1'b1;
    step();

    // exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R10 R11
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int f = 0; f < 64; f++) begin
          for (int c = 0; c < 64; c++) begin
            logic [5:0] en, q, el;
            logic [7:0] e1, e2;
            logic et;
            logic [1:0] ek;
            logic [15:0] ev;
            en = 6'(c);
            en[0] = ~en[0];
            en[4] = ~en[4];
            q  = 6'(f) & en;
            el = m ? 6'b0 : q;
            e1 = {2'b00, q[3], q[2], q[1], 1'b0, q[0], 1'b0};
            e2 = {q[5], q[4], 6'b0};
            et = (s == 1) || (el != 0);
            ek = (s == 1) ? 2'd2 : 2'd3;
            ev = 16'hFFFC;
            if (s == 0) begin
              for (int i = 5; i >= 0; i--) if (el[i]) ev = exp_vec(i);
            end
            swi_req = s[0]; i_mask = m[0]; src_flag = 6'(f); src_ctl = 6'(c);
            boundary = 1'b1;
            #1;
            check(stat1 === e1, "R5 R4 stat1", {24'b0, stat1}, {24'b0, e1});
            check(stat2 === e2, "R5 R6 stat2", {24'b0, stat2}, {24'b0, e2});
            check(stat3 === 8'd0, "R5 stat3", {24'b0, stat3}, 0);
            step();
            boundary = 1'b0;
            #1;
            if (et) begin
              expect_held("R1 R2 R3 R7 take", ek, ev);
              ack = 1'b1;
              #1;
              check(set_imask === 1'b1, "R10 set_imask", {31'b0, set_imask}, 1);
              step();
              ack = 1'b0;
              #1;
              check(take_req === 1'b0, "R11 ack clears", {31'b0, take_req}, 0);
              check(set_imask === 1'b0, "R10 idle", {31'b0, set_imask}, 0);
            end else begin
              check(take_req === 1'b0, "R3 R4 no take", {31'b0, take_req}, 0);
            end
          end
        end
      end
    end

    // R8: no selection without boundary
    swi_req = 1; i_mask = 0; src_flag = 6'h3F; src_ctl = 6'h2E; boundary = 0;
    step(); step();
    check(take_req === 1'b0, "R8 no boundary", {31'b0, take_req}, 0);

    // R8: held vector stays while inputs change
    swi_req = 0; src_flag = 6'b000100; src_ctl = 6'b010101; boundary = 1;
    step();
    expect_held("R8 load ch1", 2'd3, 16'hFFF4);
    src_flag = 6'b000001; src_ctl = 6'b000000; swi_req = 1;
    for (int k = 0; k < 3; k++) begin
      step();
      expect_held("R8 hold", 2'd3, 16'hFFF4);
    end

    // R9: reset overrides held vector with mask, ack and no boundary
    boundary = 0; i_mask = 1; ack = 1; rst_req = 1;
    #1;
    check(set_imask === 1'b0, "R10 R9 no mask set under reset", {31'b0, set_imask}, 0);
    step();
    expect_held("R9 reset override", 2'd1, 16'hFFFE);
    rst_req = 0; ack = 1;
    step();
    ack = 0; swi_req = 0;
    #1;
    check(take_req === 1'b0, "R11 reset ack", {31'b0, take_req}, 0);

    // R11: ack and boundary together load nothing on that edge
    swi_req = 1; boundary = 1;
    step();
    expect_held("R3 swi under mask", 2'd2, 16'hFFFC);
    ack = 1;
    step();
    ack = 0; boundary = 0;
    #1;
    check(take_req === 1'b0, "R11 no reload on ack edge", {31'b0, take_req}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule